// File: doc/BRIEF.md
# SD/MMC Host Interrupt Flag and Mask Unit

This block gathers the event sources of an SD/MMC host controller into one 16-bit flag register, filters them through a 16-bit mask register, and drives a single interrupt line towards the processor. Four sources are one-cycle event pulses: command response ended, programming done, data transfer done and card interrupt. Each pulse sets a sticky flag that software clears by writing a 1 to it. Two further flags are not stored. They are live service-request levels derived from the data FIFO fill level, telling software that a burst of 8 words may be written or read. Writes cannot clear them.

Software reaches both registers through a small register port. There is a select, a write strobe, a one-bit register address (0 selects the flags, 1 selects the mask), write data and combinational read data. A mask bit of 1 silences its source and a 0 lets it through. The interrupt line is high whenever any flag is set whose mask bit is clear. The asynchronous active-low reset is released through a two-stage synchronizer.

Top module: `sdmmc_irq_unit`

## Requirements
- R1: After reset every sticky flag reads 0 and every implemented mask bit (bits 0, 1, 2, 5, 6, 7, read value 0x00E7) reads 1, so the interrupt line is low.
- R2: An event pulse sets its sticky flag at the next clock edge. The flags are data transfer done at bit 0, programming done at bit 1, command response ended at bit 2 and card interrupt at bit 7.
- R3: Writing the flag register (address 0) clears each sticky flag whose write-data bit is 1 and leaves a flag whose write-data bit is 0 unchanged. A flag holds its value when neither a pulse nor a clear reaches it.
- R4: When an event pulse and a write-1-to-clear hit the same sticky flag in the same cycle, the flag ends up set.
- R5: Flag bit 6 (transmit request) reads 1 exactly when the free space of the data FIFO (depth minus fill level) is at least 8 words.
- R6: Flag bit 5 (receive request) reads 1 exactly when the fill level is at least 8 words, or when the transfer-ended input is high and the fill level is nonzero.
- R7: Writes to flag bits 5 and 6 have no effect. These bits follow only the FIFO level inputs.
- R8: The interrupt output is high in the same cycle in which some flag bit is 1 and its mask bit is 0. It is low otherwise.
- R9: Bits 3, 4 and 8 to 15 of both registers read 0 and ignore writes.
- R10: A write to the mask register (address 1) loads the implemented mask bits, and they keep that value until the next such write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 1 | 0 = flag register, 1 = mask register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed register, 0 when not selected |
| ev_xfer_done | input | 1 | Data transfer done pulse |
| ev_prog_done | input | 1 | Programming done pulse |
| ev_cmd_done | input | 1 | Command response ended pulse |
| ev_sdio | input | 1 | Card interrupt pulse |
| fifo_level | input | LVL_W (6) | Data FIFO fill level in words |
| xfer_ended | input | 1 | Data transfer has ended |
| irq_o | output | 1 | Interrupt request |

## Verification
A sticky flag stored in the wrong state shows up on the flag read and, when unmasked, on irq_o from the first cycle after the faulty edge. Such an error stays visible until a later pulse or clear overwrites it, so every pulse and clear combination is read back on the cycle after it is applied. A wrong threshold in the live FIFO requests can only be seen at particular fill levels, so every fill level from empty to full is swept with transfer-ended both low and high. Every mask pattern of the implemented bits is swept against set and cleared flags, which shows a stuck or inverted mask bit at once on irq_o.

// File: rtl/irqmu_pkg.sv
package irqmu_pkg;
  localparam int unsigned REG_W      = 16;
  localparam int unsigned NUM_LATCH  = 4;
  localparam int unsigned BIT_XFER   = 0;
  localparam int unsigned BIT_PROG   = 1;
  localparam int unsigned BIT_CMD    = 2;
  localparam int unsigned BIT_RXREQ  = 5;
  localparam int unsigned BIT_TXREQ  = 6;
  localparam int unsigned BIT_SDIO   = 7;
  localparam int unsigned LATCH_POS [NUM_LATCH] = '{BIT_XFER, BIT_PROG, BIT_CMD, BIT_SDIO};
  localparam logic [REG_W-1:0] IMPL_MASK = 16'h00E7;
  localparam logic ADDR_FLAG = 1'b0;
  localparam logic ADDR_MASK = 1'b1;
endpackage

// File: rtl/irqmu_rst_sync.sv
module irqmu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/irqmu_evt_flags.sv
module irqmu_evt_flags #(
  parameter int unsigned NUM = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NUM-1:0] ev,
  input  logic [NUM-1:0] clr,
  output logic [NUM-1:0] q
);
  for (genvar i = 0; i < NUM; i++) begin : g_flag
    logic flag_q, flag_d;

    // the event term is ORed in last so a same-cycle pulse beats the clear
    always_comb begin
      flag_d = flag_q;
      if (clr[i]) flag_d = 1'b0;
      if (ev[i])  flag_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= flag_d;
    end

    assign q[i] = flag_q;

    a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
      ev[i] |=> q[i]);
    a_r3_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !ev[i]) |=> !q[i]);
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr[i] && !ev[i]) |=> $stable(q[i]));
    a_r4_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && ev[i]) |=> q[i]);
  end
endmodule

// File: rtl/irqmu_fifo_req.sv
module irqmu_fifo_req #(
  parameter int unsigned FIFO_DEPTH = 32,
  parameter int unsigned BURST      = 8,
  parameter int unsigned LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] level,
  input  logic             ended,
  output logic             tx_req,
  output logic             rx_req
);
  localparam logic [LVL_W-1:0] DEPTH_L = LVL_W'(FIFO_DEPTH);
  localparam logic [LVL_W-1:0] BURST_L = LVL_W'(BURST);

  logic [LVL_W-1:0] space;

  always_comb begin
    space  = (level <= DEPTH_L) ? (DEPTH_L - level) : '0;
    tx_req = (space >= BURST_L);
    rx_req = (level >= BURST_L) || (ended && (level != '0));
  end

  a_r5_full_no_tx: assert property (@(posedge clk) disable iff (!rst_n)
    (level == DEPTH_L) |-> !tx_req);
  a_r5_empty_tx: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0) |-> tx_req);
  a_r6_empty_no_rx: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0) |-> !rx_req);
endmodule

// File: rtl/irqmu_mask.sv
module irqmu_mask
  import irqmu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] mask_q
);
  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    if (IMPL_MASK[i]) begin : g_impl
      logic bit_q, bit_d;
      always_comb begin
        bit_d = bit_q;
        if (wr_en) bit_d = wdata[i];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bit_q <= 1'b1;
        else        bit_q <= bit_d;
      end
      assign mask_q[i] = bit_q;
    end else begin : g_none
      assign mask_q[i] = 1'b0;
    end
  end

  a_r10_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mask_q == ($past(wdata) & IMPL_MASK)));
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mask_q));
endmodule

// File: rtl/sdmmc_irq_unit.sv
module sdmmc_irq_unit
  import irqmu_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 32,
  parameter int unsigned BURST      = 8,
  localparam int unsigned LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic             bus_addr,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  input  logic             ev_xfer_done,
  input  logic             ev_prog_done,
  input  logic             ev_cmd_done,
  input  logic             ev_sdio,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic             xfer_ended,
  output logic             irq_o
);
  logic                 rst_sync_n;
  logic                 wr_flag, wr_mask;
  logic [NUM_LATCH-1:0] ev_vec, clr_vec, lat_q;
  logic                 tx_req, rx_req;
  logic [REG_W-1:0]     flags, mask_q;

  irqmu_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign wr_flag = bus_sel && bus_we && (bus_addr == ADDR_FLAG);
  assign wr_mask = bus_sel && bus_we && (bus_addr == ADDR_MASK);
  assign ev_vec  = {ev_sdio, ev_cmd_done, ev_prog_done, ev_xfer_done};

  always_comb begin
    for (int k = 0; k < NUM_LATCH; k++) begin
      clr_vec[k] = wr_flag && bus_wdata[LATCH_POS[k]];
    end
  end

  irqmu_evt_flags #(.NUM(NUM_LATCH)) u_flags (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .ev    (ev_vec),
    .clr   (clr_vec),
    .q     (lat_q)
  );

  irqmu_fifo_req #(.FIFO_DEPTH(FIFO_DEPTH), .BURST(BURST), .LVL_W(LVL_W)) u_fifo (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .level  (fifo_level),
    .ended  (xfer_ended),
    .tx_req (tx_req),
    .rx_req (rx_req)
  );

  irqmu_mask u_mask (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_en  (wr_mask),
    .wdata  (bus_wdata),
    .mask_q (mask_q)
  );

  always_comb begin
    flags = '0;
    for (int k = 0; k < NUM_LATCH; k++) begin
      flags[LATCH_POS[k]] = lat_q[k];
    end
    flags[BIT_RXREQ] = rx_req;
    flags[BIT_TXREQ] = tx_req;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) bus_rdata = (bus_addr == ADDR_MASK) ? mask_q : flags;
  end

  assign irq_o = |(flags & ~mask_q);

  a_r8_all_masked_quiet: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((mask_q & IMPL_MASK) == IMPL_MASK) |-> !irq_o);
  a_r8_open_xfer_fires: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!mask_q[BIT_XFER] && lat_q[0]) |-> irq_o);
  a_r9_unused_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((bus_rdata & ~IMPL_MASK) == '0));
  a_r7_tx_follows_level: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_sel && !bus_we && bus_addr == ADDR_FLAG) |-> (bus_rdata[BIT_TXREQ] == tx_req));
endmodule

// File: tb/sdmmc_irq_unit_tb_top.sv
module sdmmc_irq_unit_tb_top;
  localparam int DEPTH = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0, bus_addr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        ev_xfer_done = 1'b0, ev_prog_done = 1'b0, ev_cmd_done = 1'b0, ev_sdio = 1'b0;
  logic [5:0]  fifo_level = '0;
  logic        xfer_ended = 1'b0;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] m_lat  = 16'h0000;
  logic [15:0] m_mask = 16'h00E7;

  always #5 clk = ~clk;

  sdmmc_irq_unit dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_xfer_done(ev_xfer_done),
    .ev_prog_done(ev_prog_done), .ev_cmd_done(ev_cmd_done), .ev_sdio(ev_sdio),
    .fifo_level(fifo_level), .xfer_ended(xfer_ended), .irq_o(irq_o)
  );

  function automatic logic m_tx();
    return (DEPTH - int'(fifo_level)) >= 8;
  endfunction
  function automatic logic m_rx();
    return (int'(fifo_level) >= 8) || (xfer_ended && fifo_level != 0);
  endfunction
  function automatic logic [15:0] m_flags();
    logic [15:0] f;
    f = m_lat;
    f[6] = m_tx();
    f[5] = m_rx();
    return f;
  endfunction
  function automatic logic [15:0] ev_bits(input logic [3:0] e);
    logic [15:0] b;
    b = '0;
    b[0] = e[0]; b[1] = e[1]; b[2] = e[2]; b[7] = e[3];
    return b;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic a, output logic [15:0] d, output logic irq);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    irq = irq_o;
    bus_sel = 1'b0;
  endtask

  task automatic cyc(input logic we, input logic a, input logic [15:0] wd, input logic [3:0] e);
    logic [15:0] clr;
    @(negedge clk);
    bus_sel = we; bus_we = we; bus_addr = a; bus_wdata = wd;
    {ev_sdio, ev_cmd_done, ev_prog_done, ev_xfer_done} = e;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    {ev_sdio, ev_cmd_done, ev_prog_done, ev_xfer_done} = 4'b0;
    clr = (we && a == 1'b0) ? (wd & 16'h0087) : 16'h0;
    m_lat = (m_lat & ~clr) | ev_bits(e);
    if (we && a == 1'b1) m_mask = wd & 16'h00E7;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic        irq;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(1'b0, d, irq);
    chk("R1 flags after reset", d, 16'h0040);
    chk("R1 irq after reset", {15'b0, irq}, 16'h0);
    rd(1'b1, d, irq);
    chk("R1 mask after reset", d, 16'h00E7);

    // R5 and R6: every fill level, transfer-ended low and high
    for (int en = 0; en < 2; en++) begin
      for (int lv = 0; lv <= DEPTH; lv++) begin
        fifo_level = 6'(lv);
        xfer_ended = en[0];
        rd(1'b0, d, irq);
        chk("R5 tx request", {15'b0, d[6]}, {15'b0, m_tx()});
        chk("R6 rx request", {15'b0, d[5]}, {15'b0, m_rx()});
      end
    end
    fifo_level = 6'd0;
    xfer_ended = 1'b0;

    // R2 R3 R4: every latched bit, preset state, pulse and clear
    for (int b = 0; b < 4; b++) begin
      for (int pre = 0; pre < 2; pre++) begin
        for (int e = 0; e < 2; e++) begin
          for (int c = 0; c < 2; c++) begin
            logic [3:0]  ebit;
            logic [15:0] pos;
            ebit = 4'(1 << b);
            pos  = ev_bits(ebit);
            cyc(1'b1, 1'b0, pos, 4'b0);
            if (pre != 0) cyc(1'b0, 1'b0, 16'h0, ebit);
            cyc(c[0], 1'b0, c[0] ? pos : 16'h0, e[0] ? ebit : 4'b0);
            rd(1'b0, d, irq);
            if (e != 0 && c != 0)  chk("R4 pulse beats clear", d, m_flags());
            else if (e != 0)       chk("R2 pulse sets flag", d, m_flags());
            else                   chk("R3 clear or hold", d, m_flags());
          end
        end
      end
    end

    // R3: write of zeros leaves all sticky flags set
    cyc(1'b0, 1'b0, 16'h0, 4'hF);
    cyc(1'b1, 1'b0, 16'h0000, 4'b0);
    rd(1'b0, d, irq);
    chk("R3 zero write keeps flags", d, m_flags());

    // R7 and R9: write ones everywhere in the flag register
    fifo_level = 6'd16;
    cyc(1'b1, 1'b0, 16'hFFFF, 4'b0);
    rd(1'b0, d, irq);
    chk("R7 live bits survive write", d, 16'h0060);
    chk("R9 flag unused bits zero", d & 16'hFF18, 16'h0);

    // R8 R9 R10: every mask pattern with all flags set
    cyc(1'b0, 1'b0, 16'h0, 4'hF);
    for (int m = 0; m < 256; m++) begin
      cyc(1'b1, 1'b1, {8'hFF ^ 8'(m), 8'(m)}, 4'b0);
      rd(1'b1, d, irq);
      chk("R10 mask readback", d, m_mask);
      chk("R9 mask unused bits zero", d & 16'hFF18, 16'h0);
      rd(1'b0, d, irq);
      chk("R8 irq with flags set", {15'b0, irq}, {15'b0, |(m_flags() & ~m_mask)});
    end

    // R8: sticky flags cleared, only rx request live
    cyc(1'b1, 1'b0, 16'h0087, 4'b0);
    fifo_level = 6'd32;
    for (int m = 0; m < 256; m++) begin
      cyc(1'b1, 1'b1, {8'h00, 8'(m)}, 4'b0);
      rd(1'b0, d, irq);
      chk("R8 irq rx only", {15'b0, irq}, {15'b0, |(m_flags() & ~m_mask)});
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule